// File: doc/BRIEF.md
# Stereo Serial Audio Port (Master)

This block is a clock-master serial audio port that moves one stereo frame per request. A single-cycle `start` pulse latches the frame format, the word length, the number of padding bit clocks and both transmit samples. The port then produces the bit clock and the word-select line and shifts the left and then the right sample out on `sdo`, most significant bit first. In the same bit positions it samples `sdi` into two receive words. Once both channels have shifted, `done` rises and the received pair appears on `rx_left` and `rx_right`.

Three framings are supported. In I2S framing a lead bit clock precedes the frame, so each MSB follows the word-select edge by one bit clock. In left-justified framing the MSB shares the bit clock of the word-select edge. In right-justified framing the LSB sits on the last bit clock before the edge. Each channel half lasts `word_len + pad_len` bit clocks. The bit clock is the system clock divided by `2*CLK_HALF`.

The controller has five states. `ST_IDLE` goes to `ST_LOAD` on `start`. `ST_LOAD` drives the first bit and goes to `ST_LOW`. `ST_LOW` raises the bit clock at the end of its half period and goes to `ST_HIGH`. `ST_HIGH` lowers the bit clock at the end of its half period, then returns to `ST_LOW` for the next bit, or goes to `ST_FIN` after the last bit. `ST_FIN` publishes the receive words, sets `done` and goes to `ST_IDLE`.

Top module: `aud_serial_port`

## Requirements
- R1: After reset and whenever no frame is running, `sck` is low, `ws` is high (the right-channel idle level), `sdo` is low and `busy` is low. Right after reset, `done` is low and both receive words are zero.
- R2: Let N = effective word length + `pad_len`. A frame has 2N bit clocks in left- and right-justified framing and 2N+1 in I2S framing. `ws` is low for the first N bit clocks of the frame and high for the rest.
- R3: With `fmt_sel` = 1 (left-justified), each channel half starts with the sample's MSB on its first bit clock. The word-length bits follow MSB first, and the padding bit clocks carry 0.
- R4: With `fmt_sel` = 0 (I2S), the frame opens with one lead bit clock that carries 0 with `ws` low. Each channel's MSB then arrives one bit clock after the `ws` level for that channel is set, and the padding bit clocks carry 0.
- R5: With `fmt_sel` = 2 (right-justified), each channel half starts with `pad_len` zero bits. The sample follows MSB first, so its LSB falls on the last bit clock before `ws` changes.
- R6: `sdi` is sampled on each rising `sck` edge in the data bit positions, MSB first. The received word is right-aligned in `rx_left`/`rx_right`, and every bit above the word length reads zero.
- R7: Values on `sdi` during lead or padding bit clocks never enter the receive words.
- R8: `busy` is high from the cycle after an accepted `start` until the frame ends. `done` then rises with `busy` low and stays high until the next accepted `start` clears it. `rx_left`/`rx_right` change only in the cycle in which `done` rises.
- R9: A `start` pulse while `busy` is high is ignored. The running frame keeps its latched format, lengths and samples, and no second frame follows.
- R10: A `word_len` of 0 or above 16 is treated as 16. A `fmt_sel` of 3 behaves as left-justified.
- R11: A bit clock period is 2*`CLK_HALF` system clocks, and `ws` and `sdo` change only while `sck` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle frame request |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| word_len | input | LEN_W (5) | Bits per channel sample |
| pad_len | input | PAD_W (4) | Extra bit clocks per channel half |
| tx_left | input | DATA_W (16) | Left transmit sample, right-aligned |
| tx_right | input | DATA_W (16) | Right transmit sample, right-aligned |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Bit clock |
| ws | output | 1 | Word select, low = left |
| sdo | output | 1 | Serial data out |
| rx_left | output | DATA_W (16) | Last received left word |
| rx_right | output | DATA_W (16) | Last received right word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame complete |

## Verification
The directed frames cover each framing with a full 16-bit word and no padding, which separates the I2S one-clock delay from the left-justified alignment. They also cover short words with padding, where left- and right-justified placement of the same sample differ by exactly `pad_len` positions. An all-ones `sdi` pattern over a 12-bit word with padding shows whether padding bits leak into the receive word and whether its upper bits stay zero. Out-of-range lengths, the reserved format code and a second `start` during a frame show whether the latched configuration governs the whole frame.

// File: rtl/aud_serial_pkg.sv
package aud_serial_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } frame_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_FIN
    } port_state_e;

endpackage

// File: rtl/aud_half_timer.sv
module aud_half_timer #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    generate
        if (CLK_HALF <= 1) begin : g_direct
            assign half_end = run;
        end else begin : g_count
            localparam int CW = $clog2(CLK_HALF);
            logic [CW-1:0] cnt;

            assign half_end = run && (cnt == CW'(CLK_HALF - 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (!run || half_end) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/aud_slot_decode.sv
module aud_slot_decode
    import aud_serial_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int T_W    = 7
) (
    input  logic [T_W-1:0]    t,
    input  logic [T_W-1:0]    slot_n,
    input  logic [T_W-1:0]    len,
    input  logic [T_W-1:0]    pad,
    input  frame_fmt_e        fmt,
    input  logic [DATA_W-1:0] sample_l,
    input  logic [DATA_W-1:0] sample_r,
    output logic              ws_lvl,
    output logic              data_vld,
    output logic              right_ch,
    output logic              data_bit
);
    logic             lead;
    logic [T_W-1:0]   u;
    logic [T_W-1:0]   k;
    logic [T_W-1:0]   j;
    logic [T_W-1:0]   idx;
    logic [DATA_W-1:0] sel;
    logic [DATA_W-1:0] mask;

    always_comb begin
        lead     = (fmt == FMT_I2S) && (t == '0);
        u        = (fmt == FMT_I2S) ? (t - T_W'(1)) : t;
        right_ch = (u >= slot_n);
        k        = right_ch ? (u - slot_n) : u;
        if (fmt == FMT_RJ) begin
            j        = k - pad;
            data_vld = !lead && (k >= pad);
        end else begin
            j        = k;
            data_vld = !lead && (k < len);
        end
        idx      = len - T_W'(1) - j;
        sel      = right_ch ? sample_r : sample_l;
        mask     = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
        data_bit = data_vld && (|(sel & mask));
        ws_lvl   = (t >= slot_n);
    end
endmodule

// File: rtl/aud_rx_capture.sv
module aud_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift_en,
    input  logic              right_sel,
    input  logic              din,
    output logic [DATA_W-1:0] sh_l,
    output logic [DATA_W-1:0] sh_r
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_l <= '0;
            sh_r <= '0;
        end else if (clear) begin
            sh_l <= '0;
            sh_r <= '0;
        end else if (shift_en) begin
            if (right_sel) begin
                sh_r <= {sh_r[DATA_W-2:0], din};
            end else begin
                sh_l <= {sh_l[DATA_W-2:0], din};
            end
        end
    end
endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
    import aud_serial_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int PAD_W    = 4,
    parameter int CLK_HALF = 2,
    parameter int LEN_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        fmt_sel,
    input  logic [LEN_W-1:0]  word_len,
    input  logic [PAD_W-1:0]  pad_len,
    input  logic [DATA_W-1:0] tx_left,
    input  logic [DATA_W-1:0] tx_right,
    input  logic              sdi,
    output logic              sck,
    output logic              ws,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_left,
    output logic [DATA_W-1:0] rx_right,
    output logic              busy,
    output logic              done
);
    localparam int T_W = $clog2(2 * (DATA_W + (1 << PAD_W)) + 1);

    port_state_e state, state_nx;

    frame_fmt_e        fmt_q;
    frame_fmt_e        fmt_in;
    logic [T_W-1:0]    len_q, pad_q, slot_q, total_q, t_q;
    logic [T_W-1:0]    len_in, len_eff, slot_in, total_in, t_drv;
    logic [DATA_W-1:0] txl_q, txr_q;
    logic [DATA_W-1:0] sh_l, sh_r;
    logic              cur_vld, cur_right;
    logic              half_end, last_bit, accept;
    logic              drv_ws, drv_vld, drv_right, drv_bit;

    assign busy   = (state != ST_IDLE);
    assign accept = (state == ST_IDLE) && start;

    // configuration seen at the start pulse
    always_comb begin
        fmt_in   = (fmt_sel == FMT_RSV) ? FMT_LJ : frame_fmt_e'(fmt_sel);
        len_in   = T_W'(word_len);
        len_eff  = ((len_in == '0) || (len_in > T_W'(DATA_W))) ? T_W'(DATA_W) : len_in;
        slot_in  = len_eff + T_W'(pad_len);
        total_in = {slot_in[T_W-2:0], 1'b0} + T_W'(fmt_in == FMT_I2S);
    end

    assign t_drv    = (state == ST_LOAD) ? '0 : (t_q + T_W'(1));
    assign last_bit = ((t_q + T_W'(1)) == total_q);

    aud_half_timer #(.CLK_HALF(CLK_HALF)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      ((state == ST_LOW) || (state == ST_HIGH)),
        .half_end (half_end)
    );

    aud_slot_decode #(.DATA_W(DATA_W), .T_W(T_W)) u_decode (
        .t        (t_drv),
        .slot_n   (slot_q),
        .len      (len_q),
        .pad      (pad_q),
        .fmt      (fmt_q),
        .sample_l (txl_q),
        .sample_r (txr_q),
        .ws_lvl   (drv_ws),
        .data_vld (drv_vld),
        .right_ch (drv_right),
        .data_bit (drv_bit)
    );

    aud_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .shift_en  ((state == ST_LOW) && half_end && cur_vld),
        .right_sel (cur_right),
        .din       (sdi),
        .sh_l      (sh_l),
        .sh_r      (sh_r)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)    state_nx = ST_LOAD;
            ST_LOAD:               state_nx = ST_LOW;
            ST_LOW:  if (half_end) state_nx = ST_HIGH;
            ST_HIGH: if (half_end) state_nx = last_bit ? ST_FIN : ST_LOW;
            ST_FIN:                state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck       <= 1'b0;
            ws        <= 1'b1;
            sdo       <= 1'b0;
            done      <= 1'b0;
            rx_left   <= '0;
            rx_right  <= '0;
            fmt_q     <= FMT_LJ;
            len_q     <= '0;
            pad_q     <= '0;
            slot_q    <= '0;
            total_q   <= '0;
            t_q       <= '0;
            txl_q     <= '0;
            txr_q     <= '0;
            cur_vld   <= 1'b0;
            cur_right <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fmt_q   <= fmt_in;
                        len_q   <= len_eff;
                        pad_q   <= T_W'(pad_len);
                        slot_q  <= slot_in;
                        total_q <= total_in;
                        txl_q   <= tx_left;
                        txr_q   <= tx_right;
                        t_q     <= '0;
                        done    <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    ws        <= drv_ws;
                    sdo       <= drv_bit;
                    cur_vld   <= drv_vld;
                    cur_right <= drv_right;
                end
                ST_LOW: begin
                    if (half_end) begin
                        sck <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (half_end) begin
                        sck <= 1'b0;
                        t_q <= t_q + T_W'(1);
                        if (!last_bit) begin
                            ws        <= drv_ws;
                            sdo       <= drv_bit;
                            cur_vld   <= drv_vld;
                            cur_right <= drv_right;
                        end
                    end
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    rx_left  <= sh_l;
                    rx_right <= sh_r;
                    ws       <= 1'b1;
                    sdo      <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aud_serial_port_chk.sv
module aud_serial_port_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              sck,
    input logic              ws,
    input logic              sdo,
    input logic [DATA_W-1:0] rx_left,
    input logic [DATA_W-1:0] rx_right
);
    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!sck && ws && !sdo)); // R1
    AST_WS_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(ws) |-> !sck); // R11
    AST_SDO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n) !$stable(sdo) |-> !sck); // R11
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R8
    AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $past(busy)); // R8
    AST_RX_LEFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$rose(done) |-> $stable(rx_left)); // R8
    AST_RX_RIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$rose(done) |-> $stable(rx_right)); // R8
endmodule

bind aud_serial_port aud_serial_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .sck      (sck),
    .ws       (ws),
    .sdo      (sdo),
    .rx_left  (rx_left),
    .rx_right (rx_right)
);

// File: tb/aud_serial_port_tb.sv
module aud_serial_port_tb;
    localparam int DW   = 16;
    localparam int PW   = 4;
    localparam int HALF = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    fmt_sel = 2'd1;
    logic [4:0]    word_len = 5'd16;
    logic [PW-1:0] pad_len = '0;
    logic [DW-1:0] tx_left = '0, tx_right = '0;
    logic          sdi = 1'b0;
    logic          sck, ws, sdo, busy, done;
    logic [DW-1:0] rx_left, rx_right;

    aud_serial_port #(.DATA_W(DW), .PAD_W(PW), .CLK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fmt_sel(fmt_sel),
        .word_len(word_len), .pad_len(pad_len), .tx_left(tx_left),
        .tx_right(tx_right), .sdi(sdi), .sck(sck), .ws(ws), .sdo(sdo),
        .rx_left(rx_left), .rx_right(rx_right), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // bit-clock monitor and sdi driver
    logic         sck_d = 1'b0;
    int           nbits = 0;
    int           cyc = 0;
    int           prev_rise = 0;
    int           per = 0;
    logic [127:0] cap_ws, cap_sdo, rx_pat;

    always @(negedge clk) begin
        cyc++;
        if (sck && !sck_d) begin
            if (nbits < 128) begin
                cap_ws[nbits]  = ws;
                cap_sdo[nbits] = sdo;
            end
            if (nbits > 0) per = cyc - prev_rise;
            prev_rise = cyc;
            nbits++;
        end
        if (!sck && sck_d && nbits < 128) sdi = rx_pat[nbits];
        sck_d = sck;
    end

    // expected frame
    int           e_total;
    logic [127:0] e_ws, e_sdo;
    logic [DW-1:0] e_rxl, e_rxr;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input int fm, input int wl, input int pd,
                             input logic [DW-1:0] l, input logic [DW-1:0] r);
        int mode, len, n, p;
        logic [DW-1:0] smp;
        mode = (fm == 3) ? 1 : fm;
        len  = (wl == 0 || wl > DW) ? DW : wl;
        n    = len + pd;
        p    = 0;
        e_ws = '0; e_sdo = '0; e_rxl = '0; e_rxr = '0;
        if (mode == 0) begin
            e_sdo[p] = 1'b0;
            p++;
        end
        for (int ch = 0; ch < 2; ch++) begin
            smp = (ch == 0) ? l : r;
            for (int k = 0; k < n; k++) begin
                int j;
                j = -1;
                if (mode == 2) begin
                    if (k >= pd) j = k - pd;
                end else begin
                    if (k < len) j = k;
                end
                if (j >= 0) begin
                    e_sdo[p] = smp[len - 1 - j];
                    if (ch == 0) e_rxl = (e_rxl << 1) | DW'(rx_pat[p]);
                    else         e_rxr = (e_rxr << 1) | DW'(rx_pat[p]);
                end
                p++;
            end
        end
        e_total = p;
        for (int q = 0; q < p; q++) e_ws[q] = (q >= n);
    endtask

    task automatic start_frame(input int fm, input int wl, input int pd,
                               input logic [DW-1:0] l, input logic [DW-1:0] r,
                               input logic [127:0] pat);
        @(negedge clk);
        fmt_sel  = fm[1:0];
        word_len = wl[4:0];
        pad_len  = pd[PW-1:0];
        tx_left  = l;
        tx_right = r;
        rx_pat   = pat;
        sdi      = pat[0];
        nbits    = 0;
        per      = 0;
        build_exp(fm, wl, pd, l, r);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", busy, 1);
        chk(done == 1'b0, "R8", "done cleared by start", done, 0);
    endtask

    task automatic finish_frame(input string sdo_req);
        int to;
        int bad_ws, bad_sdo;
        to = 0;
        while (!done && to < 4000) begin
            @(negedge clk);
            to++;
        end
        chk(to < 4000, "R8", "watchdog frame end", to, 0);
        chk(nbits == e_total, "R2", "bit clocks per frame", nbits, e_total);
        bad_ws = 0; bad_sdo = 0;
        for (int q = 0; q < e_total && q < 128; q++) begin
            if (cap_ws[q]  !== e_ws[q])  bad_ws++;
            if (cap_sdo[q] !== e_sdo[q]) bad_sdo++;
        end
        chk(bad_ws == 0, "R2", "ws pattern mismatches", bad_ws, 0);
        chk(bad_sdo == 0, sdo_req, "sdo pattern mismatches", bad_sdo, 0);
        chk(rx_left == e_rxl, "R6", "rx_left", rx_left, e_rxl);
        chk(rx_right == e_rxr, "R6", "rx_right", rx_right, e_rxr);
        chk(busy == 1'b0, "R8", "busy at done", busy, 0);
        chk(sck == 1'b0 && ws == 1'b1 && sdo == 1'b0, "R1", "idle lines after frame",
            {sck, ws, sdo}, 3'b010);
    endtask

    task automatic t_reset();
        chk(sck == 1'b0, "R1", "sck after reset", sck, 0);
        chk(ws == 1'b1, "R1", "ws after reset", ws, 1);
        chk(sdo == 1'b0 && busy == 1'b0 && done == 1'b0, "R1", "sdo/busy/done after reset",
            {sdo, busy, done}, 0);
        chk(rx_left == '0 && rx_right == '0, "R1", "rx words after reset", {rx_left, rx_right}, 0);
    endtask

    task automatic t_left_justified();
        start_frame(1, 16, 0, 16'hA5C3, 16'h5A3C, 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0);
        finish_frame("R3");
        start_frame(1, 9, 5, 16'h0155, 16'h00AA, 128'h3C3C_A5A5_0FF0_1234_8765_FEDC_0011_9ABC);
        finish_frame("R3");
    endtask

    task automatic t_i2s();
        start_frame(0, 16, 0, 16'h8001, 16'h7FFE, 128'h1357_9BDF_2468_ACE0_FEDC_BA98_7654_3210);
        finish_frame("R4");
        start_frame(0, 10, 2, 16'h0321, 16'h02AB, 128'hFFFF_0000_F0F0_0F0F_AAAA_5555_CCCC_3333);
        finish_frame("R4");
    endtask

    task automatic t_right_justified();
        start_frame(2, 8, 4, 16'h00C5, 16'h003A, 128'h5555_AAAA_3333_CCCC_0F0F_F0F0_1111_EEEE);
        finish_frame("R5");
        chk(rx_left[15:8] == 8'h00, "R6", "upper rx bits zero", rx_left[15:8], 0);
        start_frame(2, 16, 0, 16'hBEEF, 16'h1234, 128'h0123_4567_89AB_CDEF_0123_4567_89AB_CDEF);
        finish_frame("R5");
    endtask

    task automatic t_padding_discard();
        start_frame(1, 12, 4, 16'h0ABC, 16'h0DEF, {128{1'b1}});
        finish_frame("R3");
        chk(rx_left == 16'h0FFF, "R7", "padding sdi ignored left", rx_left, 16'h0FFF);
        chk(rx_right == 16'h0FFF, "R7", "padding sdi ignored right", rx_right, 16'h0FFF);
        start_frame(0, 6, 3, 16'h002D, 16'h0012, {128{1'b1}});
        finish_frame("R4");
        chk(rx_left == 16'h003F, "R7", "lead/pad sdi ignored", rx_left, 16'h003F);
    endtask

    task automatic t_clamp();
        start_frame(3, 0, 1, 16'hC0DE, 16'h3F21, 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C834);
        finish_frame("R10");
        start_frame(1, 20, 2, 16'h6B2D, 16'h94D2, 128'hDEAD_BEEF_CAFE_F00D_0BAD_C0DE_1357_2468);
        finish_frame("R10");
    endtask

    task automatic t_start_while_busy();
        start_frame(1, 8, 2, 16'h00E7, 16'h0018, 128'h2222_4444_8888_1111_AAAA_5555_9999_6666);
        repeat (12) @(negedge clk);
        fmt_sel  = 2'd2;
        word_len = 5'd4;
        pad_len  = 4'd7;
        tx_left  = 16'hFFFF;
        tx_right = 16'hFFFF;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_frame("R9");
        repeat (20) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b1, "R9", "no second frame", {busy, done}, 2'b01);
        chk(nbits == e_total, "R9", "bit count unchanged", nbits, e_total);
    endtask

    task automatic t_bit_period();
        start_frame(1, 4, 0, 16'h0009, 16'h0006, 128'h0);
        finish_frame("R3");
        chk(per == 2 * HALF, "R11", "sck period in clocks", per, 2 * HALF);
    endtask

    initial begin
        rx_pat = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left_justified();
        t_i2s();
        t_right_justified();
        t_padding_discard();
        t_clamp();
        t_start_while_busy();
        t_bit_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule